// File: doc/BRIEF.md
# Integer Extension Execute Unit

This unit decodes and executes a small family of custom integer instructions for a 64-bit core. Each cycle in which `valid_i` is high, it samples a 32-bit instruction word and two source operand values already read from the register file. One cycle later it presents the result, the destination register index, a write-enable and an illegal-instruction flag, all qualified by `valid_o`.

The unit covers the following operations:

- an add whose result is cut down to one byte;
- the low half of a full-width multiply;
- a population count over either the low word or the whole operand;
- an equality or inequality test against the second register;
- an equality or inequality test against a sign-extended 10-bit immediate.

Bit 0 of the function field selects the variant. For the population count it picks the word size, and for the tests it picks the polarity. Words outside the extension opcode pass through and cause no write and no fault.

Top module: `cx_int_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released with `valid_i` low, `valid_o`, `we_o` and `illegal_o` are 0.
- R2: `valid_o` is 1 exactly in the cycle after a cycle with `valid_i` = 1, and is 0 otherwise. `we_o` and `illegal_o` are 1 only while `valid_o` is 1, and are never both 1.
- R3: The extension opcode is `instr_i[31:26]` = 011100. The field in bits 25:21 names the first source, bits 20:16 (rt) name the second source, and bits 15:11 (rd) name the destination. Byte add is bits 10:0 = 00000_101000. It yields `(rs_val_i + rt_val_i) & 8'hFF`, zero-extended, with `dest_o` = rd.
- R4: Multiply is bits 10:0 = 00000_000011. It yields the low 64 bits of `rs_val_i * rt_val_i`, with `dest_o` = rd.
- R5: Population count is bits 10:1 = 00000_10110 with rt = 0. If bit 0 is 1 it counts the ones in all 64 bits of `rs_val_i`. If bit 0 is 0 it counts only bits 31:0. `dest_o` = rd.
- R6: Register compare is bits 10:1 = 00000_10101. The result is 1 if (bit 0 = 0 and `rs_val_i == rt_val_i`) or (bit 0 = 1 and they differ), and 0 otherwise. `dest_o` = rd.
- R7: Immediate compare is bits 5:1 = 10111, with a signed immediate in bits 15:6. The immediate is sign-extended to 64 bits and compared with `rs_val_i`, and bit 0 selects not-equal as in R6. The 0/1 result has `dest_o` = rt (bits 20:16).
- R8: A recognised instruction whose destination index is 0 gives `we_o` = 0 and `illegal_o` = 0.
- R9: An extension-opcode word that matches none of R3 to R7 gives `illegal_o` = 1, `we_o` = 0 and `result_o` = 0. This includes nonzero bits 10:6 on the register forms and nonzero rt on the population count.
- R10: A word whose bits 31:26 are not 011100 gives `valid_o` = 1 with `we_o` = 0, `illegal_o` = 0 and `result_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands are valid this cycle |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 64 | Value of the first source register |
| rt_val_i | input | 64 | Value of the second source register |
| valid_o | output | 1 | Registered result is valid |
| result_o | output | 64 | Result value |
| dest_o | output | 5 | Destination register index |
| we_o | output | 1 | Write the result to `dest_o` |
| illegal_o | output | 1 | Extension-opcode word with no defined meaning |

## Verification
The assertions assume that `instr_i`, `rs_val_i` and `rt_val_i` are stable and known whenever `valid_i` is high. Their result-range checks tie each output back to the instruction word sampled one cycle earlier. The stimulus drives every input at the falling clock edge and holds it through the capturing rising edge. It mixes directed corner words with random words built mostly from the legal templates. Some of those words carry stray nonzero fields or foreign opcodes. Some operand pairs are forced equal, or made to match the sign-extended immediate, so that both compare outcomes are covered.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam logic [5:0] EXT_MAJOR = 6'b011100;

  typedef enum logic [2:0] {
    CX_NONE, CX_BADD, CX_MUL, CX_POPC, CX_CMP, CX_CMPI
  } cx_op_e;

  typedef struct packed {
    cx_op_e      op;
    logic        alt;      // popc: full width, cmp: not-equal
    logic [4:0]  dest;
    logic [9:0]  imm;
    logic        ext;      // major opcode matched
    logic        illegal;
  } cx_dec_t;
endpackage

// File: rtl/cx_decode.sv
module cx_decode
  import cx_pkg::*;
(
  input  logic [31:0] instr_i,
  output cx_dec_t     dec_o
);
  logic [4:0] rt_f, rd_f, sa_f;
  logic [5:0] fn_f;
  logic       sa_zero;

  assign rt_f    = instr_i[20:16];
  assign rd_f    = instr_i[15:11];
  assign sa_f    = instr_i[10:6];
  assign fn_f    = instr_i[5:0];
  assign sa_zero = (sa_f == 5'd0);

  always_comb begin
    dec_o         = '0;
    dec_o.op      = CX_NONE;
    dec_o.alt     = fn_f[0];
    dec_o.dest    = rd_f;
    dec_o.imm     = instr_i[15:6];
    dec_o.ext     = (instr_i[31:26] == EXT_MAJOR);
    if (dec_o.ext) begin
      if (sa_zero && fn_f == 6'b101000)                         dec_o.op = CX_BADD;
      else if (sa_zero && fn_f == 6'b000011)                    dec_o.op = CX_MUL;
      else if (sa_zero && fn_f[5:1] == 5'b10110 && rt_f == 5'd0) dec_o.op = CX_POPC;
      else if (sa_zero && fn_f[5:1] == 5'b10101)                dec_o.op = CX_CMP;
      else if (fn_f[5:1] == 5'b10111) begin
        dec_o.op   = CX_CMPI;
        dec_o.dest = rt_f;
      end
      dec_o.illegal = (dec_o.op == CX_NONE);
    end
  end
endmodule

// File: rtl/cx_popcnt.sv
module cx_popcnt #(
  parameter int W     = 64,
  localparam int CW   = $clog2(W + 1)
) (
  input  logic [W-1:0]  data_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) count_o = count_o + CW'(data_i[i]);
  end
endmodule

// File: rtl/cx_exec.sv
module cx_exec
  import cx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  cx_dec_t         dec_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic [XLEN-1:0] result_o
);
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);

  logic [XLEN-1:0] pop_in, imm_ext, sum, prod;
  logic [CW-1:0]   pop_cnt;
  logic            eq_r, eq_i;

  assign pop_in  = dec_i.alt ? rs_i : {{(XLEN-HALF){1'b0}}, rs_i[HALF-1:0]};
  assign imm_ext = {{(XLEN-10){dec_i.imm[9]}}, dec_i.imm};
  assign sum     = rs_i + rt_i;
  assign prod    = rs_i * rt_i;
  assign eq_r    = (rs_i == rt_i);
  assign eq_i    = (rs_i == imm_ext);

  cx_popcnt #(.W(XLEN)) u_pop (.data_i(pop_in), .count_o(pop_cnt));

  always_comb begin
    unique case (dec_i.op)
      CX_BADD: result_o = {{(XLEN-8){1'b0}}, sum[7:0]};
      CX_MUL:  result_o = prod;
      CX_POPC: result_o = {{(XLEN-CW){1'b0}}, pop_cnt};
      CX_CMP:  result_o = {{(XLEN-1){1'b0}}, eq_r ^ dec_i.alt};
      CX_CMPI: result_o = {{(XLEN-1){1'b0}}, eq_i ^ dec_i.alt};
      default: result_o = '0;
    endcase
  end
endmodule

// File: rtl/cx_int_unit.sv
module cx_int_unit
  import cx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic [4:0]      dest_o,
  output logic            we_o,
  output logic            illegal_o
);
  cx_dec_t         dec;
  logic [XLEN-1:0] res_d;
  logic            wr_d;

  cx_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  cx_exec #(.XLEN(XLEN)) u_exe (
    .dec_i(dec), .rs_i(rs_val_i), .rt_i(rt_val_i), .result_o(res_d)
  );

  assign wr_d = (dec.op != CX_NONE) && (dec.dest != 5'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      we_o      <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
      dest_o    <= '0;
    end else begin
      valid_o   <= valid_i;
      we_o      <= valid_i && wr_d;
      illegal_o <= valid_i && dec.illegal;
      if (valid_i) begin
        result_o <= res_d;
        dest_o   <= dec.dest;
      end
    end
  end
endmodule

// File: rtl/cx_int_unit_chk.sv
module cx_int_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [31:0]     instr_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o,
  input logic [4:0]      dest_o,
  input logic            we_o,
  input logic            illegal_o
);
  logic ext, is_badd, is_cmp;
  assign ext     = (instr_i[31:26] == 6'b011100);
  assign is_badd = ext && (instr_i[10:0] == 11'b00000_101000);
  assign is_cmp  = ext && ((instr_i[10:1] == 10'b00000_10101) || (instr_i[5:1] == 5'b10111));

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_flags_qual_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o || illegal_o) |-> valid_o);
  p_flags_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_o, illegal_o}));
  p_byte_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_badd) |=> (result_o[XLEN-1:8] == '0));
  p_pop_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ext && instr_i[10:1] == 10'b00000_10110) |=> (result_o <= XLEN));
  p_cmp_bool_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_cmp) |=> (result_o[XLEN-1:1] == '0));
  p_no_zero_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (dest_o != 5'd0));
  p_foreign_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ext) |=> (!we_o && !illegal_o && result_o == '0));
endmodule

bind cx_int_unit cx_int_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
  .valid_o(valid_o), .result_o(result_o), .dest_o(dest_o),
  .we_o(we_o), .illegal_o(illegal_o)
);

// File: tb/cx_int_unit_tb.sv
module cx_int_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [31:0] instr_i;
  logic [63:0] rs_val_i, rt_val_i;
  logic        valid_o, we_o, illegal_o;
  logic [63:0] result_o;
  logic [4:0]  dest_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cx_int_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .valid_o(valid_o),
    .result_o(result_o), .dest_o(dest_o), .we_o(we_o), .illegal_o(illegal_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, sa, input logic [5:0] fn);
    return {6'b011100, rs, rt, rd, sa, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [4:0] rs, rt, input logic [9:0] imm, input logic ne);
    return {6'b011100, rs, rt, imm, 5'b10111, ne};
  endfunction

  task automatic model(input logic [31:0] w, input logic [63:0] a, b,
                       output logic we, ill, output logic [63:0] res,
                       output logic [4:0] dst, output string tag);
    logic hit;
    logic [63:0] imm;
    int lim;
    hit = 0; res = '0; dst = w[15:11]; tag = "R10";
    if (w[31:26] == 6'b011100) begin
      tag = "R9";
      if (w[10:0] == 11'b00000101000) begin
        hit = 1; res = (a + b) & 64'hFF; tag = "R3";
      end else if (w[10:0] == 11'b00000000011) begin
        hit = 1; res = a * b; tag = "R4";
      end else if (w[10:1] == 10'b0000010110 && w[20:16] == 5'd0) begin
        hit = 1; tag = "R5";
        lim = w[0] ? 64 : 32;
        for (int i = 0; i < lim; i++) res += {63'd0, a[i]};
      end else if (w[10:1] == 10'b0000010101) begin
        hit = 1; tag = "R6";
        res = {63'd0, w[0] ? (a != b) : (a == b)};
      end else if (w[5:1] == 5'b10111) begin
        hit = 1; tag = "R7"; dst = w[20:16];
        imm = {{54{w[15]}}, w[15:6]};
        res = {63'd0, w[0] ? (a != imm) : (a == imm)};
      end
    end
    ill = (w[31:26] == 6'b011100) && !hit;
    we  = hit && dst != 5'd0;
    if (hit && dst == 5'd0) tag = "R8";
  endtask

  task automatic run(input logic [31:0] w, input logic [63:0] a, b);
    logic e_we, e_ill;
    logic [63:0] e_res;
    logic [4:0] e_dst;
    string tag;
    model(w, a, b, e_we, e_ill, e_res, e_dst, tag);
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = w; rs_val_i = a; rt_val_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R2 valid_o", {63'd0, valid_o}, 64'd1);
    check({tag, " we_o"}, {63'd0, we_o}, {63'd0, e_we});
    check({tag, " illegal_o"}, {63'd0, illegal_o}, {63'd0, e_ill});
    check({tag, " result_o"}, result_o, e_res);
    if (e_we) check({tag, " dest_o"}, {59'd0, dest_o}, {59'd0, e_dst});
    @(negedge clk_i);
    check("R2 valid_o idle", {61'd0, valid_o, we_o, illegal_o}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    logic [31:0] w;
    logic [9:0]  imm;
    void'($urandom(32'd20240607));
    rst_ni = 1'b0; valid_i = 1'b0; instr_i = '0; rs_val_i = '0; rt_val_i = '0;
    repeat (3) @(negedge clk_i);
    check("R1 reset flags", {61'd0, valid_o, we_o, illegal_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", {61'd0, valid_o, we_o, illegal_o}, 64'd0);

    // directed corners
    run(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b101000), 64'hFF, 64'h01);                 // R3 wrap
    run(enc_r(5'd1, 5'd2, 5'd4, 5'd0, 6'b101000), 64'hFFFF_FFFF_FFFF_FF80, 64'h7F); // R3
    run(enc_r(5'd1, 5'd2, 5'd5, 5'd0, 6'b000011), 64'hFFFF_FFFF_FFFF_FFFF, 64'h3);  // R4
    run(enc_r(5'd1, 5'd2, 5'd5, 5'd0, 6'b000011), 64'h1_0000_0001, 64'h1_0000_0001);// R4
    run(enc_r(5'd1, 5'd0, 5'd6, 5'd0, 6'b101100), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);  // R5 word
    run(enc_r(5'd1, 5'd0, 5'd6, 5'd0, 6'b101101), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);  // R5 dword
    run(enc_r(5'd1, 5'd0, 5'd6, 5'd0, 6'b101100), 64'hF0F0_0000_0000_0001, 64'h0);  // R5 high ignored
    run(enc_r(5'd1, 5'd2, 5'd7, 5'd0, 6'b101010), 64'h1234, 64'h1234);              // R6 eq
    run(enc_r(5'd1, 5'd2, 5'd7, 5'd0, 6'b101011), 64'h1234, 64'h1234);              // R6 ne
    run(enc_r(5'd1, 5'd2, 5'd7, 5'd0, 6'b101011), 64'h1234, 64'h1235);              // R6 ne
    run(enc_i(5'd1, 5'd9, 10'h3FF, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);          // R7 -1
    run(enc_i(5'd1, 5'd9, 10'h200, 1'b1), 64'hFFFF_FFFF_FFFF_FE00, 64'h0);          // R7 min
    run(enc_i(5'd1, 5'd9, 10'h1FF, 1'b0), 64'h1FF, 64'h0);                          // R7 max
    run(enc_r(5'd1, 5'd2, 5'd0, 5'd0, 6'b101000), 64'h5, 64'h6);                    // R8
    run(enc_i(5'd1, 5'd0, 10'h5, 1'b0), 64'h5, 64'h0);                              // R8 imm
    run(enc_r(5'd1, 5'd2, 5'd3, 5'd1, 6'b101000), 64'h5, 64'h6);                    // R9 sa
    run(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b101100), 64'h5, 64'h6);                    // R9 rt
    run(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b000000), 64'h5, 64'h6);                    // R9 fn
    run({6'b000000, 26'h0431828}, 64'h5, 64'h6);                                    // R10

    for (int n = 0; n < N_RAND; n++) begin
      int k;
      logic [4:0] sa;
      k   = int'($urandom % 8);
      a   = {$urandom, $urandom};
      b   = ($urandom % 4 == 0) ? a : {$urandom, $urandom};
      sa  = ($urandom % 8 == 0) ? 5'($urandom) : 5'd0;
      imm = 10'($urandom);
      case (k)
        0: w = enc_r(5'($urandom), 5'($urandom), 5'($urandom), sa, 6'b101000);
        1: w = enc_r(5'($urandom), 5'($urandom), 5'($urandom), sa, 6'b000011);
        2: w = enc_r(5'($urandom), ($urandom % 8 == 0) ? 5'($urandom) : 5'd0,
                     5'($urandom), sa, {5'b10110, 1'($urandom)});
        3: w = enc_r(5'($urandom), 5'($urandom), 5'($urandom), sa, {5'b10101, 1'($urandom)});
        4: begin
          w = enc_i(5'($urandom), 5'($urandom), imm, 1'($urandom));
          if ($urandom % 2 == 0) a = {{54{imm[9]}}, imm};
        end
        5: w = {6'($urandom), 26'($urandom)};
        6: w = {6'b011100, 26'($urandom)};
        default: w = enc_r(5'($urandom), 5'($urandom), 5'($urandom), 5'd0, 6'($urandom));
      endcase
      run(w, a, b);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule